// File: doc/BRIEF.md
# Two-Source Bit-Rate Strobe Generator

This block produces the bit-period strobe a serial transmitter or receiver uses to time its bits. Two timing references arrive as single-cycle enable pulses in one clock domain: a main reference and a crystal reference. A 32-bit configuration word picks the reference, the prescale factor and a divisor. The chosen reference is first cut down by a fixed prescaler (4 for the main reference; 3 or 2 for the crystal). The result is then divided again by the programmed divisor plus one. Each time the second counter wraps, the block emits a one-cycle strobe.

Configuration word layout: bits [22:0] divisor D; bit 23 enables the divisor (0 stops all strobes); bit 24 selects the crystal (1) or the main reference (0); bit 27 picks crystal prescale 2 (1) or 3 (0). All other bits are don't-care. Software computes D as round(prescaled rate / baud) - 1 and writes the word only while the serial line is idle. Every write restarts both counters from zero.

Control is a two-state machine. `ST_OFF` (the reset state) moves to `ST_RUN` on a write with bit 23 set. `ST_RUN` returns to `ST_OFF` on a write with bit 23 clear. A write in `ST_RUN` that keeps bit 23 set stays in `ST_RUN` and restarts the counters. With no write, each state holds.

Top module: `baud_strobe_gen`

## Requirements
- R1: After reset the block is in ST_OFF and bit_tick stays 0, whatever the reference pulses do, until a configuration write with bit 23 set.
- R2: While the last write had bit 23 = 0, bit_tick stays 0 whatever the reference pulses do.
- R3: With bit 24 = 0, bit_tick pulses once for every 4*(D+1) main_tick pulses, and xtal_tick has no effect.
- R4: With bit 24 = 1 and bit 27 = 0, bit_tick pulses once for every 3*(D+1) xtal_tick pulses, and main_tick has no effect.
- R5: With bit 24 = 1 and bit 27 = 1, bit_tick pulses once for every 2*(D+1) xtal_tick pulses.
- R6: The divisor D is taken from bits [22:0]. D = 0 gives a strobe on every prescaler output, and the counter never exceeds D.
- R7: bit_tick is high for exactly one cycle. It is high in the cycle after the clock edge that samples the reference pulse completing the period.
- R8: Any write restarts the prescaler and divisor from zero. Reference pulses sampled on the write edge are discarded, and bit_tick is 0 in the following cycle.
- R9: Bit 27 has no effect when bit 24 = 0.
- R10: Bits 25, 26 and 28 to 31 of the configuration word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| main_tick | input | 1 | Main reference enable pulse |
| xtal_tick | input | 1 | Crystal reference enable pulse |
| bit_tick | output | 1 | One-cycle bit-period strobe |

## Verification
A configuration write takes effect on the edge that samples it, and bit_tick is guaranteed low in the next cycle. A strobe appears in the cycle right after the edge that samples the completing reference pulse. The bench drives each cycle's inputs on the falling edge and updates its arithmetic pulse-count model on the rising edge. It then compares bit_tick one nanosecond later, so every cycle is checked exactly when its result is due. The sweep covers every source and prescale combination, several divisors (including zero and the maximum), enabled and disabled words, and mid-run rewrites, under both sparse pseudo-random and back-to-back pulse patterns.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    parameter int REG_W     = 32;
    parameter int DIV_W     = 23;
    parameter int EN_BIT    = 23;
    parameter int XSEL_BIT  = 24;
    parameter int XDIV2_BIT = 27;
    parameter int PRE_W     = 2;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } gen_state_t;

    // Terminal count of the prescaler: factor minus one.
    function automatic logic [PRE_W-1:0] pre_limit(input logic xsel, input logic xdiv2);
        if (!xsel)
            return PRE_W'(3);
        else if (xdiv2)
            return PRE_W'(1);
        else
            return PRE_W'(2);
    endfunction
endpackage

// File: rtl/baud_ctrl_fsm.sv
module baud_ctrl_fsm
    import baud_gen_pkg::*;
#(
    parameter int DW = baud_gen_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             run,
    output logic             restart,
    output logic             xsel,
    output logic             xdiv2,
    output logic [DW-1:0]    divisor
);
    gen_state_t state_q, state_d;
    logic          xsel_q, xdiv2_q;
    logic [DW-1:0] div_q;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[REG_W-1:XDIV2_BIT+1], cfg_wdata[XDIV2_BIT-1:XSEL_BIT+1]};

    // State register and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            xsel_q  <= 1'b0;
            xdiv2_q <= 1'b0;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_wr) begin
                xsel_q  <= cfg_wdata[XSEL_BIT];
                xdiv2_q <= cfg_wdata[XDIV2_BIT];
                div_q   <= cfg_wdata[DW-1:0];
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (cfg_wr && cfg_wdata[EN_BIT])  state_d = ST_RUN;
            ST_RUN: if (cfg_wr && !cfg_wdata[EN_BIT]) state_d = ST_OFF;
        endcase
        run     = (state_q == ST_RUN);
        restart = cfg_wr;
        xsel    = xsel_q;
        xdiv2   = xdiv2_q;
        divisor = div_q;
    end

    // R2
    en_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (run == $past(cfg_wdata[EN_BIT])));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic xsel,
    input  logic xdiv2,
    input  logic main_tick,
    input  logic xtal_tick,
    output logic pre_tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;
    logic             src_tick;

    always_comb begin
        lim      = pre_limit(xsel, xdiv2);
        src_tick = xsel ? xtal_tick : main_tick;
        pre_tick = run && !clear && src_tick && (cnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run)
            cnt_q <= '0;
        else if (src_tick)
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DW = baud_gen_pkg::DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [DW-1:0] divisor,
    input  logic          pre_tick,
    output logic          strobe
);
    logic [DW-1:0] cnt_q;
    logic          strobe_q;
    logic          wrap;

    assign wrap   = pre_tick && (cnt_q == divisor);
    assign strobe = strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= wrap;
            if (pre_tick)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
    // R7
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> $past(pre_tick));
    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !strobe_q);
    // R6
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
        cnt_q <= divisor);
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0 && !strobe_q));
endmodule

// File: rtl/baud_strobe_gen.sv
module baud_strobe_gen
    import baud_gen_pkg::*;
#(
    parameter int DW = baud_gen_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             main_tick,
    input  logic             xtal_tick,
    output logic             bit_tick
);
    logic          run, restart, xsel, xdiv2, pre_tick;
    logic [DW-1:0] divisor;

    baud_ctrl_fsm #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .run(run), .restart(restart), .xsel(xsel), .xdiv2(xdiv2), .divisor(divisor)
    );

    baud_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clear(restart), .run(run), .xsel(xsel),
        .xdiv2(xdiv2), .main_tick(main_tick), .xtal_tick(xtal_tick), .pre_tick(pre_tick)
    );

    baud_divider #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(restart), .run(run),
        .divisor(divisor), .pre_tick(pre_tick), .strobe(bit_tick)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !bit_tick);
endmodule

// File: tb/baud_strobe_gen_test.sv
`timescale 1ns/1ps
module baud_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        main_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        bit_tick;

    always #2 clk = ~clk;

    baud_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .main_tick(main_tick), .xtal_tick(xtal_tick), .bit_tick(bit_tick)
    );

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;
    bit dense = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    bit m_en = 1'b0, m_xsel = 1'b0, m_x2 = 1'b0;
    int m_div = 0, m_cnt = 0;

    function automatic int period();
        return (m_xsel ? (m_x2 ? 2 : 3) : 4) * (m_div + 1);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    task automatic step(input bit wr, input logic [31:0] data, input string tag);
        bit mt, xt, exp_t;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mt = dense ? 1'b1 : lfsr[0];
        xt = dense ? 1'b1 : lfsr[5];
        cfg_wr = wr; cfg_wdata = data; main_tick = mt; xtal_tick = xt;
        @(posedge clk);
        exp_t = 1'b0;
        if (!rst_n) begin
            m_en = 1'b0; m_cnt = 0;
        end else if (wr) begin
            m_en = data[23]; m_xsel = data[24]; m_x2 = data[27];
            m_div = int'(data[22:0]); m_cnt = 0;
        end else if (m_en && (m_xsel ? xt : mt)) begin
            m_cnt++;
            if (m_cnt == period()) begin exp_t = 1'b1; m_cnt = 0; end
        end
        #1;
        vectors++;
        if (bit_tick !== exp_t) begin
            misses++;
            $display("FAIL %s%s: bit_tick=%0b expected %0b", tag, exp_t ? " R7" : "", bit_tick, exp_t);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run incomplete=1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int divs[6] = '{0, 1, 2, 3, 4, 9};
        // R1: reset state with reference pulses active
        for (int i = 0; i < 3; i++) step(1'b0, 32'h0, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) step(1'b0, 32'h0, "R1");

        // src 0: main (R3), 1: main with bit 27 set (R9), 2: crystal /3 (R4), 3: crystal /2 (R5)
        for (int src = 0; src < 4; src++) begin
            for (int di = 0; di < 6; di++) begin
                for (int en = 0; en < 2; en++) begin
                    logic [31:0] w;
                    string tag;
                    bit x2, xs;
                    xs = (src >= 2);
                    x2 = (src == 1) || (src == 3);
                    // R10: garbage in bits 31:28 and 26:25
                    w = {4'b1010, x2, 2'b11, xs, en[0], 23'(divs[di])};
                    dense = (divs[di] == 9) || (src == 3 && divs[di] == 0);
                    if (en == 0) tag = "R2";
                    else if (src == 0) tag = "R3";
                    else if (src == 1) tag = "R9";
                    else if (src == 2) tag = "R4";
                    else tag = "R5";
                    if (divs[di] == 0) tag = {tag, " R6"};
                    tag = {tag, " R10"};
                    step(1'b1, w, "R8");
                    for (int k = 0; k < 41; k++) step(1'b0, 32'h0, tag);
                    // R8: rewrite mid-period restarts the phase
                    step(1'b1, w, "R8");
                    for (int k = 0; k < 45; k++) step(1'b0, 32'h0, tag);
                end
            end
        end

        // R6: maximum divisor yields no strobe within the window
        dense = 1'b1;
        step(1'b1, {8'h00, 1'b1, 23'h7FFFFF}, "R8");
        for (int k = 0; k < 200; k++) step(1'b0, 32'h0, "R6");
        // R2: disable after running
        step(1'b1, {8'h00, 1'b1, 23'd1}, "R8");
        for (int k = 0; k < 20; k++) step(1'b0, 32'h0, "R3");
        step(1'b1, {8'h00, 1'b0, 23'd1}, "R8");
        for (int k = 0; k < 30; k++) step(1'b0, 32'h0, "R2");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule